// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block models a synchronous static RAM with burst addressing. The word count is a parameter, and each word holds four byte lanes of a parameterized width. One rising clock edge registers an address, which is taken either from the external address input or from an internal two-bit burst counter. The counter steps through a four-word group in either an interleaved (XOR) order or a linear order. A cycle is opened by one of two active-low address strobes: the processor strobe or the controller strobe. Each strobe has its own gating by three chip enables. Later edges continue the burst, suspend it or close it.

The read path has two settings. In pipelined operation, data is presented one clock after the address edge. In flow-through operation, data is presented in the same cycle as the address edge. The bidirectional data bus is split into a data input, a data output and an output-drive flag. Writes go through a byte-write decode that can select all lanes at once or individual lanes. A sleep input freezes the block. While it is high, no access is taken and the stored contents are kept.

Top module: `burstSramCore`

## Requirements
- R1: A synchronous reset (rst high) leaves the block deselected with dataOe low. A continue edge that follows reset (both strobes high, advN low) does not turn dataOe on.
- R2: The processor strobe (adspN low) opens a cycle only when ce0N is low. The cycle is a read at addrIn if ce1 is high and ce2N is low; otherwise the block is deselected. On that edge the write inputs and advN have no effect. When ce0N is high, the processor strobe is treated as high, so the edge acts as a continue edge.
- R3: The controller strobe (adscN low) opens a cycle only when adspN is high on the same edge. If adspN is also low with ce0N low, the processor cycle wins and the edge is a read. With adspN high, any inactive chip enable (including ce0N high) deselects the block. When the enables are valid, the write inputs sampled on that edge can make the opening edge a write at addrIn.
- R4: The write decode works in three cases. When gwN is low, all four lanes are written. When gwN is high and bweN is low, lane i is written if bwN[i] is low; lane i is bits [i*LANE_W +: LANE_W]. When all bwN are high, or when bweN and gwN are both high, the cycle is a read and memory is unchanged.
- R5: With flowN high (pipelined), data for a read address registered on edge E is presented, with dataOe high, after edge E+1.
- R6: With flowN low (flow-through), data for a read address registered on edge E is presented, with dataOe high, after edge E itself.
- R7: dataOe is low in the cycle after any edge that takes a write, whatever oeN is. oeN high turns dataOe off at once, without waiting for a clock edge.
- R8: On a continue edge (both strobes high, block selected), advN low moves to the next burst address and advN high keeps the current one. After four steps the burst wraps to its first address.
- R9: The upper address bits stay fixed during a burst. For step k, the low two bits are start^k when seqXor is 1, and (start+k) mod 4 when seqXor is 0.
- R10: A deselect is single-cycle. In flow-through, dataOe is low after the deselect edge. In pipelined, the read from the edge before the deselect is still presented for one cycle, and dataOe is low from the following edge on.
- R11: While sleep is high, dataOe is low and edges take no access. Memory, the registered address and the burst position are held, so after sleep falls the burst resumes where it stopped.
- R12: A continue edge that has write enables writes dataIn to the burst address of that edge. That is the next address when advN is low and the current address when advN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | AW | External word address |
| dataIn | input | DW | Write data, sampled on write edges |
| dataOut | output | DW | Read data |
| dataOe | output | 1 | High when the block would drive the bus |
| ce0N | input | 1 | Master chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2N | input | 1 | Chip enable, active low |
| adspN | input | 1 | Processor address strobe, active low |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte write qualifier, active low |
| bwN | input | 4 | Per-lane write enables, active low |
| oeN | input | 1 | Output enable, asynchronous, active low |
| flowN | input | 1 | Low selects flow-through reads, high selects pipelined reads |
| seqXor | input | 1 | 1 selects interleaved burst order, 0 selects linear order |
| sleep | input | 1 | Low-power hold, active high |

## Verification
In pipelined operation, a read taken on one edge is still on its way to the outputs when the next edge arrives. That next edge can take a write or a deselect, so two things happen in the same cycle. The bench provokes both cases directly: it follows a processor-strobe read with a suspended continue write, and it follows a suspended read with a controller-strobe deselect. For the write, it checks that dataOe is low after the write edge even though oeN is low. For the deselect, it checks that the in-flight word is still presented for exactly one more cycle. Random write bursts with mixed lane masks and advance patterns are then read back in both read modes and compared against a bench memory model.

// File: rtl/sramPkg.sv
package sramPkg;
  localparam int LANES = 4;
  localparam int BURST_BITS = 2;

  typedef struct packed {
    logic             wrEn;
    logic [LANES-1:0] laneWr;
    logic             loadOut;
  } strobe_t;
endpackage

// File: rtl/burstCounter.sv
module burstCounter #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] loadLow,
  input  logic          step,
  input  logic          seqXor,
  output logic [CW-1:0] curLow,
  output logic [CW-1:0] nextLow
);
  logic [CW-1:0] baseLow;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cntNext;

  function automatic logic [CW-1:0] mapStep(input logic [CW-1:0] b,
                                            input logic [CW-1:0] k,
                                            input logic          x);
    return x ? (b ^ k) : (b + k);
  endfunction

  assign cntNext = cnt + 1'b1;
  assign curLow  = mapStep(baseLow, cnt, seqXor);
  assign nextLow = mapStep(baseLow, cntNext, seqXor);

  always_ff @(posedge clk) begin
    if (rst) begin
      baseLow <= '0;
      cnt     <= '0;
    end else if (load) begin
      baseLow <= loadLow;
      cnt     <= '0;
    end else if (step) begin
      cnt <= cntNext;
    end
  end

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> ((curLow == $past(nextLow)) || (seqXor != $past(seqXor))));

  // R9
  seq_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    nextLow != curLow);
endmodule

// File: rtl/sramCtl.sv
module sramCtl import sramPkg::*; #(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addrIn,
  input  logic             ce0N,
  input  logic             ce1,
  input  logic             ce2N,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             oeN,
  input  logic             flowN,
  input  logic             seqXor,
  input  logic             sleep,
  output strobe_t          strb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    curAddr,
  output logic             dataOe
);
  localparam int UW = AW - BURST_BITS;

  logic [UW-1:0]         upperReg;
  logic                  active;
  logic                  rdCycle;
  logic                  rdPipe;
  logic                  wrLast;
  logic [BURST_BITS-1:0] curLow;
  logic [BURST_BITS-1:0] nextLow;

  logic             enOk;
  logic             procHit;
  logic             ctrlHit;
  logic             strobeHit;
  logic [LANES-1:0] laneReq;
  logic             wrReq;
  logic             beginCyc;
  logic             deselCyc;
  logic             contCyc;
  logic             stepCyc;
  logic             wrTake;
  logic             rdTake;
  logic             driveOn;

  always_comb begin
    enOk      = !ce0N && ce1 && !ce2N;
    procHit   = !adspN && !ce0N;
    ctrlHit   = !procHit && !adscN;
    strobeHit = procHit || ctrlHit;
    if (!gwN)       laneReq = '1;
    else if (!bweN) laneReq = ~bwN;
    else            laneReq = '0;
    wrReq    = |laneReq;
    beginCyc = !sleep && strobeHit && enOk;
    deselCyc = !sleep && strobeHit && !enOk;
    contCyc  = !sleep && !strobeHit && active;
    stepCyc  = contCyc && !advN;
    wrTake   = (beginCyc && ctrlHit && wrReq) || (contCyc && wrReq);
    rdTake   = (beginCyc && !(ctrlHit && wrReq)) || (contCyc && !wrReq);
  end

  burstCounter #(.CW(BURST_BITS)) i_burstCounter (
    .clk     (clk),
    .rst     (rst),
    .load    (beginCyc),
    .loadLow (addrIn[BURST_BITS-1:0]),
    .step    (stepCyc),
    .seqXor  (seqXor),
    .curLow  (curLow),
    .nextLow (nextLow)
  );

  assign curAddr = {upperReg, curLow};
  assign wrAddr  = beginCyc ? addrIn : {upperReg, (stepCyc ? nextLow : curLow)};

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      upperReg <= '0;
      rdCycle  <= 1'b0;
      rdPipe   <= 1'b0;
      wrLast   <= 1'b0;
    end else begin
      if (deselCyc)      active <= 1'b0;
      else if (beginCyc) active <= 1'b1;
      if (beginCyc) upperReg <= addrIn[AW-1:BURST_BITS];
      rdCycle <= rdTake;
      rdPipe  <= rdCycle && !sleep;
      wrLast  <= wrTake;
    end
  end

  assign driveOn      = flowN ? (rdPipe && !wrLast) : rdCycle;
  assign dataOe       = driveOn && !oeN && !sleep;
  assign strb.wrEn    = wrTake;
  assign strb.laneWr  = laneReq;
  assign strb.loadOut = rdCycle && !sleep;

  // R7
  wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    strb.wrEn |=> !dataOe);

  // R2
  proc_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!adspN && !ce0N && !sleep) |-> !strb.wrEn);

  // R10
  desel_flow_chk: assert property (@(posedge clk) disable iff (rst)
    (!flowN && !sleep && ((!adspN && !ce0N) || !adscN) && !(!ce0N && ce1 && !ce2N))
      |=> !dataOe);

  // R10
  desel_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    (flowN && !sleep && ((!adspN && !ce0N) || !adscN) && !(!ce0N && ce1 && !ce2N))
      |-> ##2 !dataOe);

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(curAddr) && !dataOe));
endmodule

// File: rtl/sramData.sv
module sramData import sramPkg::*; #(
  parameter int DEPTH = 256,
  parameter int LW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LANES * LW
) (
  input  logic          clk,
  input  strobe_t       strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] dataIn,
  input  logic          flowN,
  output logic [DW-1:0] dataOut
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LW-1:0] laneMem [DEPTH];
    logic [LW-1:0] outReg;

    always_ff @(posedge clk) begin
      if (strb.wrEn && strb.laneWr[g]) laneMem[wrAddr] <= dataIn[g*LW +: LW];
      if (strb.loadOut) outReg <= laneMem[rdAddr];
    end

    assign dataOut[g*LW +: LW] = flowN ? outReg : laneMem[rdAddr];
  end
endmodule

// File: rtl/burstSramCore.sv
module burstSramCore import sramPkg::*; #(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addrIn,
  input  logic [DW-1:0]    dataIn,
  output logic [DW-1:0]    dataOut,
  output logic             dataOe,
  input  logic             ce0N,
  input  logic             ce1,
  input  logic             ce2N,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             oeN,
  input  logic             flowN,
  input  logic             seqXor,
  input  logic             sleep
);
  strobe_t       strb;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] curAddr;

  sramCtl #(.AW(AW)) i_sramCtl (
    .clk     (clk),
    .rst     (rst),
    .addrIn  (addrIn),
    .ce0N    (ce0N),
    .ce1     (ce1),
    .ce2N    (ce2N),
    .adspN   (adspN),
    .adscN   (adscN),
    .advN    (advN),
    .gwN     (gwN),
    .bweN    (bweN),
    .bwN     (bwN),
    .oeN     (oeN),
    .flowN   (flowN),
    .seqXor  (seqXor),
    .sleep   (sleep),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .curAddr (curAddr),
    .dataOe  (dataOe)
  );

  sramData #(.DEPTH(DEPTH), .LW(LANE_W)) i_sramData (
    .clk     (clk),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .rdAddr  (curAddr),
    .dataIn  (dataIn),
    .flowN   (flowN),
    .dataOut (dataOut)
  );
endmodule

// File: tb/test_burstSramCore.sv
`timescale 1ns/1ps
module test_burstSramCore;
  localparam int DEPTH = 256;
  localparam int LW    = 8;
  localparam int AW    = 8;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addrIn;
  logic [DW-1:0] dataIn;
  logic [DW-1:0] dataOut;
  logic          dataOe;
  logic          ce0N, ce1, ce2N, adspN, adscN, advN, gwN, bweN, oeN, flowN, seqXor, sleep;
  logic [3:0]    bwN;

  logic [DW-1:0] model [DEPTH];
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  burstSramCore #(.DEPTH(DEPTH), .LANE_W(LW)) i_burstSramCore (
    .clk(clk), .rst(rst), .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .ce0N(ce0N), .ce1(ce1), .ce2N(ce2N), .adspN(adspN),
    .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN),
    .flowN(flowN), .seqXor(seqXor), .sleep(sleep)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleIn();
    adspN = 1'b1; adscN = 1'b1; advN = 1'b1;
    gwN = 1'b1; bweN = 1'b1; bwN = 4'hF;
    ce0N = 1'b0; ce1 = 1'b1; ce2N = 1'b0;
  endtask

  function automatic logic [AW-1:0] burstAddr(input logic [AW-1:0] base, input int k, input logic x);
    logic [1:0] kk;
    kk = k[1:0];
    return {base[AW-1:2], (x ? (base[1:0] ^ kk) : (base[1:0] + kk))};
  endfunction

  function automatic logic [3:0] laneMask(input logic gw, input logic bwe, input logic [3:0] bw);
    if (!gw) return 4'hF;
    if (!bwe) return ~bw;
    return 4'h0;
  endfunction

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'd3};
  endfunction

  task automatic applyWrite(input logic [AW-1:0] a, input logic [3:0] m, input logic [DW-1:0] d);
    for (int l = 0; l < 4; l++)
      if (m[l]) model[a][l*LW +: LW] = d[l*LW +: LW];
  endtask

  task automatic ctrlWrite(input logic [AW-1:0] a, input logic gw, input logic bwe,
                           input logic [3:0] bw, input logic [DW-1:0] d);
    adscN = 1'b0; addrIn = a; gwN = gw; bweN = bwe; bwN = bw; dataIn = d;
    tick();
    applyWrite(a, laneMask(gw, bwe, bw), d);
    idleIn();
  endtask

  task automatic contWrite(input logic adv, input logic gw, input logic bwe, input logic [3:0] bw,
                           input logic [DW-1:0] d, input logic [AW-1:0] a);
    advN = adv; gwN = gw; bweN = bwe; bwN = bw; dataIn = d;
    tick();
    applyWrite(a, laneMask(gw, bwe, bw), d);
    idleIn();
  endtask

  task automatic procRead(input logic [AW-1:0] a);
    adspN = 1'b0; addrIn = a;
    tick();
    idleIn();
  endtask

  task automatic contEdge(input logic adv);
    advN = adv;
    tick();
    idleIn();
  endtask

  task automatic rdBurst(input logic [AW-1:0] base, input logic pipe);
    procRead(base);
    if (!pipe) begin
      check("R6 flow burst word 0", dataOut, model[base]);
      for (int k = 1; k < 4; k++) begin
        contEdge(1'b0);
        check("R9 flow burst word", dataOut, model[burstAddr(base, k, seqXor)]);
      end
    end else begin
      for (int k = 1; k < 4; k++) begin
        contEdge(1'b0);
        check("R5 pipe burst word", dataOut, model[burstAddr(base, k - 1, seqXor)]);
        check("R5 pipe burst drive", {31'b0, dataOe}, 32'd1);
      end
      contEdge(1'b1);
      check("R9 pipe burst last", dataOut, model[burstAddr(base, 3, seqXor)]);
    end
  endtask

  task automatic randWriteBurst(input logic [AW-1:0] base);
    int k;
    logic gw, bwe, adv;
    logic [3:0] bw;
    k = 0;
    gw = ($urandom_range(0, 3) == 0) ? 1'b0 : 1'b1;
    bwe = $urandom_range(0, 1); bw = $urandom_range(0, 15);
    ctrlWrite(base, gw, bwe, bw, $urandom);
    for (int e = 1; e < 4; e++) begin
      adv = $urandom_range(0, 1);
      if (!adv) k++;
      gw = ($urandom_range(0, 3) == 0) ? 1'b0 : 1'b1;
      bwe = $urandom_range(0, 1); bw = $urandom_range(0, 15);
      contWrite(adv, gw, bwe, bw, $urandom, burstAddr(base, k, seqXor));
    end
  endtask

  task automatic doReset(input logic fl);
    rst = 1'b1; flowN = fl;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; addrIn = '0; dataIn = '0; oeN = 1'b0; flowN = 1'b0; seqXor = 1'b1; sleep = 1'b0;
    idleIn();
    tick(); tick(); tick();
    rst = 1'b0;
    check("R1 reset drive off", {31'b0, dataOe}, 32'd0);
    contEdge(1'b0);
    check("R1 continue after reset no drive", {31'b0, dataOe}, 32'd0);

    for (int a = 0; a < DEPTH; a++) ctrlWrite(a[AW-1:0], 1'b0, 1'b1, 4'hF, pat(a[AW-1:0]));

    // R2 / R6: processor strobe read, flow-through
    procRead(8'd5);
    check("R6 flow data same cycle", dataOut, model[5]);
    check("R6 flow drive on", {31'b0, dataOe}, 32'd1);
    // R2: write inputs ignored on processor edge
    adspN = 1'b0; addrIn = 8'd6; gwN = 1'b0; dataIn = 32'hFFFF_FFFF;
    tick(); idleIn();
    check("R2 proc edge is read", dataOut, model[6]);
    check("R2 proc edge drive", {31'b0, dataOe}, 32'd1);
    // R2: processor strobe blocked by ce0N, edge continues burst 6 -> 7
    ce0N = 1'b1; adspN = 1'b0; addrIn = 8'd40; advN = 1'b0;
    tick(); idleIn();
    check("R2 blocked strobe continues", dataOut, model[7]);
    // R2: inactive ce1 deselects
    ce1 = 1'b0; adspN = 1'b0; addrIn = 8'd9;
    tick(); idleIn();
    check("R2 ce1 deselect", {31'b0, dataOe}, 32'd0);
    // R3: processor wins over controller
    adspN = 1'b0; adscN = 1'b0; addrIn = 8'd10; gwN = 1'b0; dataIn = 32'h0;
    tick(); idleIn();
    check("R3 proc wins read", dataOut, model[10]);
    check("R3 proc wins drive", {31'b0, dataOe}, 32'd1);
    // R3: controller strobe with ce0N high deselects, no write
    adscN = 1'b0; ce0N = 1'b1; addrIn = 8'd11; gwN = 1'b0; dataIn = 32'h1234_5678;
    tick(); idleIn();
    check("R3 ce0 deselect", {31'b0, dataOe}, 32'd0);
    procRead(8'd11);
    check("R3 deselect no write", dataOut, model[11]);
    // R3 begin write, R7 drive off after write
    ctrlWrite(8'd12, 1'b0, 1'b1, 4'hF, 32'hCAFE_0012);
    check("R7 flow write drive off", {31'b0, dataOe}, 32'd0);
    procRead(8'd12);
    check("R3 controller write", dataOut, 32'hCAFE_0012);

    // R4 byte lanes
    ctrlWrite(8'd20, 1'b0, 1'b1, 4'hF, 32'h0);
    ctrlWrite(8'd20, 1'b1, 1'b0, 4'b1010, 32'hAABB_CCDD);
    ctrlWrite(8'd20, 1'b1, 1'b1, 4'b0000, 32'hFFFF_FFFF);
    ctrlWrite(8'd20, 1'b1, 1'b0, 4'hF, 32'hFFFF_FFFF);
    procRead(8'd20);
    check("R4 lane mask result", dataOut, 32'h00BB_00DD);

    // R8 suspend and wrap, R9 interleaved order
    seqXor = 1'b1;
    procRead(8'd13);
    contEdge(1'b1);
    check("R8 suspend holds", dataOut, model[13]);
    contEdge(1'b0); check("R9 xor step1", dataOut, model[12]);
    contEdge(1'b0); check("R9 xor step2", dataOut, model[15]);
    contEdge(1'b0); check("R9 xor step3", dataOut, model[14]);
    contEdge(1'b0); check("R8 wrap to start", dataOut, model[13]);
    seqXor = 1'b0;
    procRead(8'd13);
    contEdge(1'b0); check("R9 linear step1", dataOut, model[14]);
    contEdge(1'b0); check("R9 linear step2", dataOut, model[15]);
    contEdge(1'b0); check("R9 linear step3", dataOut, model[12]);
    seqXor = 1'b1;

    // R12 continue writes
    ctrlWrite(8'd30, 1'b0, 1'b1, 4'hF, 32'h1111_1111);
    contWrite(1'b1, 1'b0, 1'b1, 4'hF, 32'h2222_2222, 8'd30);
    contWrite(1'b0, 1'b0, 1'b1, 4'hF, 32'h3333_3333, 8'd31);
    procRead(8'd30);
    check("R12 suspended write", dataOut, 32'h2222_2222);
    contEdge(1'b0);
    check("R12 advanced write", dataOut, 32'h3333_3333);

    // R7 asynchronous output enable
    procRead(8'd5);
    oeN = 1'b1; #1;
    check("R7 oeN high drive off", {31'b0, dataOe}, 32'd0);
    oeN = 1'b0; #1;
    check("R7 oeN low drive on", {31'b0, dataOe}, 32'd1);

    // R11 sleep
    procRead(8'd40);
    sleep = 1'b1; #1;
    check("R11 sleep drive off", {31'b0, dataOe}, 32'd0);
    adscN = 1'b0; addrIn = 8'd41; gwN = 1'b0; dataIn = 32'hDEAD_BEEF;
    tick(); idleIn();
    advN = 1'b0; tick(); idleIn();
    sleep = 1'b0;
    contEdge(1'b1);
    check("R11 address held", dataOut, model[40]);
    contEdge(1'b0);
    check("R11 burst resumes no write", dataOut, model[41]);

    // R10 flow deselect
    procRead(8'd50);
    adscN = 1'b0; ce2N = 1'b1;
    tick(); idleIn();
    check("R10 flow deselect off", {31'b0, dataOe}, 32'd0);

    // random phase, flow-through
    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] b;
      b = $urandom_range(0, DEPTH - 1);
      seqXor = $urandom_range(0, 1);
      randWriteBurst(b);
      rdBurst(b, 1'b0);
    end

    // pipelined phase
    seqXor = 1'b1;
    doReset(1'b1);
    procRead(8'd60);
    check("R5 pipe empty after first edge", {31'b0, dataOe}, 32'd0);
    contEdge(1'b1);
    check("R5 pipe data next edge", dataOut, model[60]);
    check("R5 pipe drive on", {31'b0, dataOe}, 32'd1);
    adscN = 1'b0; ce2N = 1'b1;
    tick(); idleIn();
    check("R10 pipe in-flight drive", {31'b0, dataOe}, 32'd1);
    check("R10 pipe in-flight data", dataOut, model[60]);
    tick();
    check("R10 pipe deselect off", {31'b0, dataOe}, 32'd0);
    procRead(8'd61);
    contWrite(1'b1, 1'b0, 1'b1, 4'hF, 32'h6161_6161, 8'd61);
    check("R7 pipe write kills drive", {31'b0, dataOe}, 32'd0);
    procRead(8'd61);
    contEdge(1'b1);
    check("R12 pipe write landed", dataOut, 32'h6161_6161);

    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] b;
      b = $urandom_range(0, DEPTH - 1);
      seqXor = $urandom_range(0, 1);
      randWriteBurst(b);
      rdBurst(b, 1'b1);
    end

    summary();
    $finish;
  end
endmodule